// File: doc/BRIEF.md
# Shift and Rotate Unit

This block performs the bit-shifting and rotating operations of a 32-bit integer datapath. It covers six operations: arithmetic shifts to the left and to the right, logical shifts to the left and to the right, and rotates to the left and to the right. Each operation works on a byte, a word or a longword. Only the low 8, 16 or 32 bits of the operand take part, and any bits above the selected size pass through unchanged.

The shift count has three possible sources: a 3-bit immediate field, the contents of a data register, or the constant one. The unit returns the result together with the negative, zero, overflow, carry and extend flags. Shifts copy the last bit that leaves the operand into both carry and extend. Rotates are circular, and they keep the extend flag as it was.

The datapath is a single-cycle shifter with one output register. A request is accepted whenever `in_valid` is high. Its result appears on the outputs one clock later, marked by `out_valid`. Operand fetch and instruction decode are done by the surrounding pipeline.

Top module: `shr_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and the outputs carry that request's result. After a rising edge with `in_valid` low, `out_valid` is low and the result and flag outputs hold their last values. Reset clears `out_valid`, the result and every flag.
- R2: `cnt_src` selects the count. Code 0 selects `cnt_imm`, where 1 to 7 are taken as given and 0 means 8. Code 1 selects `cnt_reg` modulo 64. Codes 2 and 3 select a count of one.
- R3: `size` code 0 selects a byte (bits 7:0), code 1 a word (bits 15:0), and codes 2 and 3 a longword. Result bits above the selected size equal the operand's bits.
- R4: Op codes: 0 is arithmetic left, 1 is arithmetic right, 2 is logical left, 3 is logical right. Logical shifts and the arithmetic left shift fill vacated positions with zero. The arithmetic right shift fills them with the sign bit of the selected size.
- R5: For op codes 0 to 3 with a nonzero count, C and X both receive the last bit shifted out. A count larger than the size gives this outcome: a zero result with C=X=0 for the left shifts and the logical right shift, and every bit equal to the sign, with C=X=sign, for the arithmetic right shift.
- R6: Op code 4 rotates left and op code 5 rotates right. Each bit that leaves one end enters the other end. C receives the last bit rotated out: the result's lsb for a left rotate and the result's msb for a right rotate. X always equals `x_in`.
- R7: V is set for op code 0 when the msb of the selected size takes a different value at any step of the shift. V is 0 for every other operation.
- R8: When the effective count is zero, the result equals the operand, C=0, V=0 and X equals `x_in`.
- R9: N equals the msb of the selected size of the result. Z is 1 exactly when the selected size of the result is all zero.
- R10: Op codes 6 and 7 return the operand unchanged, with C=0, V=0 and X equal to `x_in`. N and Z are computed as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (R4, R6, R10) |
| size | input | 2 | Operand size code (R3) |
| cnt_src | input | 2 | Count source select (R2) |
| cnt_imm | input | 3 | Immediate count field |
| cnt_reg | input | 32 | Data register used as the count |
| operand | input | 32 | Value to be shifted |
| x_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Shifted or rotated value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
The assertions check these rules on every cycle:
- the one-cycle latency from request to result;
- the passthrough of operand bits above the selected size;
- that rotates and the unused op codes leave X equal to `x_in`;
- that V stays clear outside the arithmetic left shift;
- that C equals X after any nonzero-count shift;
- the zero-count rule.

The actual shifted values, and which bit lands in C, can only be shown by the bench scenarios. These are compared against a separately written model. They cover the immediate-zero-means-eight and modulo-64 count rules, counts that exceed the operand size, sign filling, and overflow detection.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned SHR_DATA_W = 32;
  localparam int unsigned SHR_CNT_W  = 6;
  localparam int unsigned SHR_IMM_W  = 3;

  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shr_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LNG2 = 2'd3
  } shr_size_e;

  typedef enum logic [1:0] {
    CS_IMM  = 2'd0,
    CS_REG  = 2'd1,
    CS_ONE  = 2'd2,
    CS_ONE2 = 2'd3
  } shr_cnt_src_e;

  function automatic logic is_rotate(shr_op_e op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction

  function automatic logic is_shift(shr_op_e op);
    return (op == OP_ASL) || (op == OP_ASR) || (op == OP_LSL) || (op == OP_LSR);
  endfunction
endpackage

// File: rtl/shr_count_sel.sv
module shr_count_sel
  import shr_pkg::*;
#(
  parameter int unsigned DATA_W = SHR_DATA_W,
  parameter int unsigned CNT_W  = SHR_CNT_W,
  parameter int unsigned IMM_W  = SHR_IMM_W
) (
  input  shr_cnt_src_e       src,
  input  logic [IMM_W-1:0]   imm,
  input  logic [DATA_W-1:0]  reg_val,
  output logic [CNT_W-1:0]   eff_cnt
);
  localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);
  localparam logic [CNT_W-1:0] ONE_CNT      = CNT_W'(1);

  logic [CNT_W-1:0] imm_cnt;
  logic [CNT_W-1:0] reg_cnt;
  logic             unused_reg_hi;

  assign imm_cnt = (imm == '0) ? IMM_ZERO_CNT : CNT_W'(imm);
  assign reg_cnt = reg_val[CNT_W-1:0];
  assign unused_reg_hi = ^reg_val[DATA_W-1:CNT_W];

  always_comb begin
    unique case (src)
      CS_IMM:  eff_cnt = imm_cnt;
      CS_REG:  eff_cnt = reg_cnt;
      default: eff_cnt = ONE_CNT;
    endcase
  end
endmodule

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
#(
  parameter int unsigned DATA_W = SHR_DATA_W,
  parameter int unsigned CNT_W  = SHR_CNT_W
) (
  input  shr_op_e            op,
  input  shr_size_e          size,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [DATA_W-1:0]  data,
  input  logic               x_in,
  output logic [DATA_W-1:0]  res,
  output logic               n_o,
  output logic               z_o,
  output logic               v_o,
  output logic               c_o,
  output logic               x_o
);
  localparam int unsigned STEPS = 1 << CNT_W;
  localparam int unsigned PACK_W = DATA_W + 5;

  function automatic logic [DATA_W-1:0] size_mask(shr_size_e sz);
    unique case (sz)
      SZ_BYTE: return DATA_W'(8'hFF);
      SZ_WORD: return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  function automatic int size_msb(shr_size_e sz);
    unique case (sz)
      SZ_BYTE: return 7;
      SZ_WORD: return 15;
      default: return int'(DATA_W) - 1;
    endcase
  endfunction

  // One bit per step, repeated cnt times: the loop gives the bench a
  // structure entirely unlike its own closed-form model.
  function automatic logic [PACK_W-1:0] shr_eval(
    shr_op_e op_f, shr_size_e sz_f, logic [CNT_W-1:0] cnt_f,
    logic [DATA_W-1:0] d_f, logic x_f);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] val;
    logic              out_b, sgn, c_v, x_v, v_v;
    int                m;
    mask = size_mask(sz_f);
    m    = size_msb(sz_f);
    val  = d_f & mask;
    c_v  = 1'b0;
    x_v  = x_f;
    v_v  = 1'b0;
    for (int i = 0; i < int'(STEPS); i++) begin
      if (i < int'(cnt_f)) begin
        case (op_f)
          OP_ASL, OP_LSL: begin
            out_b = val[m];
            val   = (val << 1) & mask;
            if ((op_f == OP_ASL) && (val[m] != out_b)) v_v = 1'b1;
            c_v = out_b;
            x_v = out_b;
          end
          OP_ASR: begin
            out_b  = val[0];
            sgn    = val[m];
            val    = val >> 1;
            val[m] = sgn;
            c_v = out_b;
            x_v = out_b;
          end
          OP_LSR: begin
            out_b = val[0];
            val   = val >> 1;
            c_v = out_b;
            x_v = out_b;
          end
          OP_ROL: begin
            out_b = val[m];
            val   = ((val << 1) & mask) | DATA_W'(out_b);
            c_v   = out_b;
          end
          OP_ROR: begin
            out_b  = val[0];
            val    = val >> 1;
            val[m] = out_b;
            c_v    = out_b;
          end
          default: ;
        endcase
      end
    end
    return {(d_f & ~mask) | val, val[m], (val == '0), v_v, c_v, x_v};
  endfunction

  logic [PACK_W-1:0] packed_out;

  assign packed_out = shr_eval(op, size, cnt, data, x_in);
  assign res = packed_out[PACK_W-1:5];
  assign n_o = packed_out[4];
  assign z_o = packed_out[3];
  assign v_o = packed_out[2];
  assign c_o = packed_out[1];
  assign x_o = packed_out[0];
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int unsigned DATA_W = SHR_DATA_W,
  parameter int unsigned CNT_W  = SHR_CNT_W,
  parameter int unsigned IMM_W  = SHR_IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [1:0]        cnt_src,
  input  logic [IMM_W-1:0]  cnt_imm,
  input  logic [DATA_W-1:0] cnt_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic              x_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_x
);
  shr_op_e          op_e;
  shr_size_e        size_e;
  shr_cnt_src_e     src_e;
  logic [CNT_W-1:0] eff_cnt;
  logic             op_is_rot;
  logic             op_is_shift;
  logic             cnt_is_zero;
  logic [DATA_W-1:0] nxt_res;
  logic             nxt_n, nxt_z, nxt_v, nxt_c, nxt_x;

  assign op_e        = shr_op_e'(op);
  assign size_e      = shr_size_e'(size);
  assign src_e       = shr_cnt_src_e'(cnt_src);
  assign op_is_rot   = is_rotate(op_e);
  assign op_is_shift = is_shift(op_e);
  assign cnt_is_zero = (eff_cnt == '0);

  shr_count_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_count (
    .src     (src_e),
    .imm     (cnt_imm),
    .reg_val (cnt_reg),
    .eff_cnt (eff_cnt)
  );

  shr_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .op   (op_e),
    .size (size_e),
    .cnt  (eff_cnt),
    .data (operand),
    .x_in (x_in),
    .res  (nxt_res),
    .n_o  (nxt_n),
    .z_o  (nxt_z),
    .v_o  (nxt_v),
    .c_o  (nxt_c),
    .x_o  (nxt_x)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      flag_x    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        flag_n <= nxt_n;
        flag_z <= nxt_z;
        flag_v <= nxt_v;
        flag_c <= nxt_c;
        flag_x <= nxt_x;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_byte_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_e == SZ_BYTE) |=> (result[DATA_W-1:8] == $past(operand[DATA_W-1:8])));

  p_shift_c_eq_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_shift && !cnt_is_zero) |=> (flag_c == flag_x));

  p_rot_keeps_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_rot) |=> (flag_x == $past(x_in)));

  p_v_only_asl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e != OP_ASL) |=> !flag_v);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_is_zero) |=>
      (result == $past(operand) && !flag_c && !flag_v && flag_x == $past(x_in)));

  p_reserved_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_is_rot && !op_is_shift) |=>
      (result == $past(operand) && !flag_c && flag_x == $past(x_in)));
endmodule

// File: tb/shr_unit_bench.sv
module shr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [1:0]  cnt_src = '0;
  logic [2:0]  cnt_imm = '0;
  logic [31:0] cnt_reg = '0;
  logic [31:0] operand = '0;
  logic        x_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c, flag_x;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [36:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [36:0] last_exp = '0;

  always #5 clk = ~clk;

  shr_unit u_shr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .cnt_src(cnt_src), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .operand(operand),
    .x_in(x_in), .out_valid(out_valid), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_x(flag_x)
  );

  // Closed-form model written from the requirements: {result, N, Z, V, C, X}
  function automatic logic [36:0] ref_model(logic [2:0] o, logic [1:0] sz, logic [1:0] src,
      logic [2:0] imm, logic [31:0] rg, logic [31:0] d_in, logic xi);
    int w, m, cnt, rr;
    logic [31:0] mask, d, r;
    logic [95:0] t;
    logic c, x, v, first, b, sgn;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = w - 1;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    cnt = (src == 2'd0) ? ((imm == 3'd0) ? 8 : int'(imm)) : (src == 2'd1) ? int'(rg[5:0]) : 1;
    d = d_in & mask; r = d; c = 1'b0; v = 1'b0; x = xi;
    case (o)
      3'd0, 3'd2: begin
        t = {64'd0, d} << cnt;
        r = t[31:0] & mask;
        c = t[w];
      end
      3'd1: begin
        sgn = d[m];
        t = {{63{sgn}}, d | (sgn ? ~mask : 32'd0), 1'b0};
        t = $signed(t) >>> cnt;
        c = t[0];
        r = t[32:1] & mask;
      end
      3'd3: begin
        t = {63'd0, d, 1'b0} >> cnt;
        c = t[0];
        r = t[32:1] & mask;
      end
      3'd4: begin
        rr = cnt % w;
        r = ((d << rr) | (d >> (w - rr))) & mask;
        c = (cnt != 0) ? r[0] : 1'b0;
      end
      3'd5: begin
        rr = cnt % w;
        r = ((d >> rr) | (d << (w - rr))) & mask;
        c = (cnt != 0) ? r[m] : 1'b0;
      end
      default: begin r = d; c = 1'b0; end
    endcase
    if (o <= 3'd3 && cnt != 0) x = c;
    if (o == 3'd0 && cnt != 0) begin
      first = d[m];
      for (int k = 1; k <= cnt; k++) begin
        b = (m - k >= 0) ? d[m - k] : 1'b0;
        if (b != first) v = 1'b1;
      end
    end
    return {(d_in & ~mask) | r, r[m], (r == 32'd0), v, c, x};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] sz, input logic [1:0] src,
      input logic [2:0] imm, input logic [31:0] rg, input logic [31:0] d, input logic xi,
      input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op = o; size = sz; cnt_src = src; cnt_imm = imm;
    cnt_reg = rg; operand = d; x_in = xi;
    it.exp = ref_model(o, sz, src, imm, rg, d, xi);
    it.tag = tag;
    last_exp = it.exp;
    sb_q.push_back(it);
  endtask

  // Monitor: pops one expected item per result strobe
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [36:0] act;
      item_t it;
      act = {result, flag_n, flag_z, flag_v, flag_c, flag_x};
      if (sb_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", act, '0);
      end else begin
        it = sb_q.pop_front();
        check(act === it.exp, it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == 32'd0 && {flag_n, flag_z, flag_v, flag_c, flag_x} == 5'd0,
          "R1 reset state", {result, flag_n, flag_z, flag_v, flag_c, flag_x}, '0);
    rst_n = 1'b1;

    // R4 fill rules
    drive(3'd2, 2'd0, 2'd0, 3'd3, 32'd0, 32'h0000_0081, 1'b0, "R4 LSL byte");
    drive(3'd3, 2'd1, 2'd0, 3'd5, 32'd0, 32'h0000_F0F3, 1'b0, "R4 LSR word");
    drive(3'd1, 2'd0, 2'd0, 3'd2, 32'd0, 32'h0000_0080, 1'b0, "R4 ASR byte negative");
    drive(3'd1, 2'd2, 2'd0, 3'd4, 32'd0, 32'h8000_1234, 1'b1, "R4 ASR long");
    // R2 count sources
    drive(3'd2, 2'd2, 2'd0, 3'd0, 32'd0, 32'h0000_00FF, 1'b0, "R2 imm zero means 8");
    drive(3'd3, 2'd2, 2'd1, 3'd2, 32'd65, 32'h0000_0003, 1'b0, "R2 reg count mod 64");
    drive(3'd2, 2'd1, 2'd2, 3'd5, 32'd9, 32'h0000_8001, 1'b0, "R2 constant one");
    // R3 upper bits pass through
    drive(3'd3, 2'd0, 2'd0, 3'd1, 32'd0, 32'hDEAD_BE81, 1'b0, "R3 byte upper kept");
    drive(3'd4, 2'd1, 2'd0, 3'd4, 32'd0, 32'hCAFE_1234, 1'b0, "R3 word upper kept");
    // R5 counts beyond size
    drive(3'd2, 2'd0, 2'd1, 3'd0, 32'd9, 32'h0000_00FF, 1'b0, "R5 LSL byte count 9");
    drive(3'd1, 2'd0, 2'd1, 3'd0, 32'd20, 32'h0000_0090, 1'b0, "R5 ASR byte count 20");
    drive(3'd3, 2'd2, 2'd1, 3'd0, 32'd40, 32'hFFFF_FFFF, 1'b1, "R5 LSR long count 40");
    drive(3'd0, 2'd1, 2'd1, 3'd0, 32'd16, 32'h0000_0001, 1'b0, "R5 ASL word count 16");
    // R6 rotates
    drive(3'd4, 2'd0, 2'd2, 3'd0, 32'd0, 32'h0000_0081, 1'b0, "R6 ROL byte");
    drive(3'd5, 2'd1, 2'd1, 3'd0, 32'd17, 32'h0000_0001, 1'b1, "R6 ROR word count 17");
    drive(3'd4, 2'd2, 2'd0, 3'd0, 32'd0, 32'h8123_4567, 1'b1, "R6 ROL long 8");
    drive(3'd5, 2'd0, 2'd1, 3'd0, 32'd63, 32'h0000_0006, 1'b0, "R6 ROR byte count 63");
    // R7 overflow
    drive(3'd0, 2'd0, 2'd2, 3'd0, 32'd0, 32'h0000_0040, 1'b0, "R7 ASL msb changes");
    drive(3'd0, 2'd0, 2'd2, 3'd0, 32'd0, 32'h0000_0020, 1'b0, "R7 ASL no change");
    drive(3'd0, 2'd0, 2'd0, 3'd2, 32'd0, 32'h0000_00C0, 1'b0, "R7 ASL change second step");
    drive(3'd2, 2'd0, 2'd2, 3'd0, 32'd0, 32'h0000_0040, 1'b0, "R7 LSL clears V");
    // R8 zero count
    drive(3'd2, 2'd2, 2'd1, 3'd0, 32'd64, 32'h8000_0001, 1'b1, "R8 zero count shift");
    drive(3'd4, 2'd0, 2'd1, 3'd0, 32'h0000_0100, 32'h0000_0081, 1'b0, "R8 zero count rotate");
    // R9 flags
    drive(3'd3, 2'd1, 2'd0, 3'd1, 32'd0, 32'h0000_0001, 1'b0, "R9 zero result");
    drive(3'd2, 2'd1, 2'd2, 3'd0, 32'd0, 32'h0000_4000, 1'b0, "R9 negative result");
    // R10 unused codes
    drive(3'd6, 2'd0, 2'd0, 3'd3, 32'd0, 32'h1234_5680, 1'b1, "R10 op 6");
    drive(3'd7, 2'd2, 2'd1, 3'd0, 32'd5, 32'h0000_0000, 1'b0, "R10 op 7");

    // Mixed pseudo-random stream
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b2;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b2 = lf * 32'h9E37_79B9;
      drive(a[2:0], a[4:3], a[6:5], a[9:7], {26'd0, a[15:10]}, b2, a[16], "R9 mixed stream");
    end

    // R1: idle cycle drops out_valid and holds the outputs
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && {result, flag_n, flag_z, flag_v, flag_c, flag_x} == last_exp,
          "R1 hold after idle", {result, flag_n, flag_z, flag_v, flag_c, flag_x}, last_exp);
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R1 all results delivered", 37'(sb_q.size()), '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule